// File: doc/BRIEF.md
# Pixel Component Extraction Unit

This block sits between a framebuffer fetch path and a display output. Each clock it receives one raw pixel word that holds one to four bytes, plus two qualifiers: one saying the pixel lies inside the visible area and one saying the fetch path ran dry. It turns that word into 8-bit red, green and blue values. Each colour is cut from its own programmable bit field of the word, and the result is scaled to eight bits.

Software programs the block through a plain write strobe with a two-bit register select. One register holds the pixel width in bytes. Three per-colour select words each carry the field's lowest bit index, the field length and a fallback value. The fallback replaces the extracted colour whenever the field length is zero, the pixel is outside the visible area, or the source underran. A fallback of 0xFF on red with zero on green and blue therefore paints every underrun pixel pure red.

Top module: `pix_comp_extract`

## Requirements
- R1: While rst_n is low all outputs are zero, the pixel width resets to one byte, and every colour select resets to fallback 0, length 0 and offset 0.
- R2: A write with cfg_sel = 0 sets the pixel width to (cfg_data[4:3] + 1) bytes. The other bits of that write have no effect.
- R3: Writes with cfg_sel = 1, 2 and 3 load the red, green and blue select words. In each, bits [23:16] are the fallback value, bits [11:8] are the field length (0 to 15) and bits [4:0] are the lowest bit index. All other bits are ignored.
- R4: A colour whose field length is zero outputs its fallback value.
- R5: While pix_active is low, every colour outputs its fallback value.
- R6: While pix_underrun is high, every colour outputs its fallback value. With fallbacks red 0xFF, green 0x00 and blue 0x00, underrun pixels come out as 0xFF/0x00/0x00.
- R7: For a field length L of 8 or more, the output is the top eight bits of the field, which are word bits offset+L-1 down to offset+L-8.
- R8: For a field length L from 1 to 7, the field fills the top L output bits and is repeated downward, so that output bit i equals field bit L-1-((7-i) mod L).
- R9: Word bits at or above 8 times the configured byte count, and bit positions above 31, read as zero.
- R10: Colour outputs follow their inputs by exactly one clock. out_active and out_underrun are pix_active and pix_underrun delayed by the same single clock.
- R11: A configuration write is seen by the pixel presented in the cycle after the write edge. Bus activity with cfg_we low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 width, 1 red, 2 green, 3 blue |
| cfg_data | input | 32 | Configuration write data |
| pix_word | input | 32 | Raw pixel word, byte 0 in bits [7:0] |
| pix_active | input | 1 | Pixel lies in the visible area |
| pix_underrun | input | 1 | Pixel source underran |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |
| out_active | output | 1 | pix_active delayed one clock |
| out_underrun | output | 1 | pix_underrun delayed one clock |

## Verification
The bench targets fields that run past the configured byte count or past bit 31. A design that forgot the byte mask would leak stale upper bytes into the colour. It drives short fields of every length from 1 to 7 at varied offsets, where a wrong repetition or alignment would give dim or banded colours. It also overlaps blanking, underrun and zero-length fields, because a design that checked only one qualifier would emit garbage at the borders. Finally it writes a new select word while pixels stream and also shows junk on the bus with the strobe low, which exposes an off-by-one in when a setting takes effect and any decode that ignores the strobe.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam int PCE_OUT_W = 8;
    localparam int PCE_LEN_W = 4;
    localparam int PCE_OFF_W = 5;
    localparam int PCE_NCOL  = 3;

    typedef enum logic [1:0] {
        REG_WIDTH = 2'd0,
        REG_RED   = 2'd1,
        REG_GREEN = 2'd2,
        REG_BLUE  = 2'd3
    } pce_reg_e;

    typedef struct packed {
        logic [PCE_OUT_W-1:0] dflt;
        logic [PCE_LEN_W-1:0] len;
        logic [PCE_OFF_W-1:0] off;
    } pce_sel_t;
endpackage

// File: rtl/pce_cfg_regs.sv
module pce_cfg_regs
    import pce_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [1:0]              sel,
    input  logic [DW-1:0]           data,
    output logic [1:0]              bytes_m1,
    output pce_sel_t [PCE_NCOL-1:0] col_sel
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_m1 <= '0;
            col_sel  <= '0;
        end else if (we) begin
            unique case (pce_reg_e'(sel))
                REG_WIDTH: bytes_m1   <= data[4:3];
                REG_RED:   col_sel[0] <= '{dflt: data[23:16], len: data[11:8], off: data[4:0]};
                REG_GREEN: col_sel[1] <= '{dflt: data[23:16], len: data[11:8], off: data[4:0]};
                REG_BLUE:  col_sel[2] <= '{dflt: data[23:16], len: data[11:8], off: data[4:0]};
            endcase
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(bytes_m1) && $stable(col_sel))); // R11
    AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd0) |=> (bytes_m1 == $past(data[4:3]))); // R2
endmodule

// File: rtl/pce_byte_mask.sv
module pce_byte_mask #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] word_i,
    input  logic [1:0]    bytes_m1,
    output logic [DW-1:0] word_o
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign word_o[b*8 +: 8] = (b <= int'(bytes_m1)) ? word_i[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pce_lane.sv
module pce_lane
    import pce_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        word_i,
    input  pce_sel_t             sel_i,
    input  logic                 act_i,
    input  logic                 und_i,
    output logic [PCE_OUT_W-1:0] comp_o
);
    localparam int FW  = (1 << PCE_LEN_W) - 1;
    localparam int ACW = PCE_OUT_W * FW;

    logic [2*DW-1:0]      wide;
    logic [FW:0]          len_mask;
    logic [FW-1:0]        field;
    logic [PCE_OUT_W-1:0] long_val;
    logic [PCE_OUT_W-1:0] short_val;
    logic [ACW-1:0]       acc;
    logic [7:0]           short_sh;
    logic                 use_dflt;

    always_comb begin
        wide     = {{DW{1'b0}}, word_i} >> sel_i.off;
        len_mask = (FW+1)'((FW+1)'(1) << sel_i.len) - (FW+1)'(1);
        field    = wide[FW-1:0] & len_mask[FW-1:0];
        long_val = PCE_OUT_W'(field >> (sel_i.len - PCE_LEN_W'(PCE_OUT_W)));
        acc = '0;
        for (int k = 0; k < PCE_OUT_W; k++) begin
            acc = (acc << sel_i.len) | ACW'(field);
        end
        short_sh  = 8'(int'(sel_i.len) * PCE_OUT_W - PCE_OUT_W);
        short_val = PCE_OUT_W'(acc >> short_sh);
        use_dflt  = !act_i || und_i || (sel_i.len == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_o <= '0;
        end else if (use_dflt) begin
            comp_o <= sel_i.dflt;
        end else if (int'(sel_i.len) >= PCE_OUT_W) begin
            comp_o <= long_val;
        end else begin
            comp_o <= short_val;
        end
    end

    AST_BLANK_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> (comp_o == $past(sel_i.dflt))); // R5
    AST_UNDER_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
        und_i |=> (comp_o == $past(sel_i.dflt))); // R6
    AST_ZLEN_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i.len == '0) |=> (comp_o == $past(sel_i.dflt))); // R4
    AST_BYTE0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && !und_i && sel_i.len == 4'd8 && sel_i.off == '0)
        |=> (comp_o == $past(word_i[7:0]))); // R7
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
    import pce_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_data,
    input  logic [DW-1:0] pix_word,
    input  logic          pix_active,
    input  logic          pix_underrun,
    output logic [7:0]    out_red,
    output logic [7:0]    out_green,
    output logic [7:0]    out_blue,
    output logic          out_active,
    output logic          out_underrun
);
    logic [1:0]              bytes_m1;
    pce_sel_t [PCE_NCOL-1:0] col_sel;
    logic [DW-1:0]           masked;
    logic [PCE_OUT_W-1:0]    comp [PCE_NCOL];

    pce_cfg_regs #(.DW(DW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .data     (cfg_data),
        .bytes_m1 (bytes_m1),
        .col_sel  (col_sel)
    );

    pce_byte_mask #(.DW(DW)) u_mask (
        .word_i   (pix_word),
        .bytes_m1 (bytes_m1),
        .word_o   (masked)
    );

    for (genvar c = 0; c < PCE_NCOL; c++) begin : g_lane
        pce_lane #(.DW(DW)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .word_i (masked),
            .sel_i  (col_sel[c]),
            .act_i  (pix_active),
            .und_i  (pix_underrun),
            .comp_o (comp[c])
        );
    end

    assign out_red   = comp[0];
    assign out_green = comp[1];
    assign out_blue  = comp[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_active   <= 1'b0;
            out_underrun <= 1'b0;
        end else begin
            out_active   <= pix_active;
            out_underrun <= pix_underrun;
        end
    end

    AST_QUAL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_active == $past(pix_active) && out_underrun == $past(pix_underrun))); // R10
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (out_red == 8'h00 && out_active == 1'b0)); // R1
endmodule

// File: tb/pix_comp_extract_test.sv
module pix_comp_extract_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_data = '0;
    logic [31:0] pix_word = '0;
    logic        pix_active = 1'b0;
    logic        pix_underrun = 1'b0;
    logic [7:0]  out_red, out_green, out_blue;
    logic        out_active, out_underrun;

    always #5 clk = ~clk;

    pix_comp_extract uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .pix_word(pix_word), .pix_active(pix_active),
        .pix_underrun(pix_underrun), .out_red(out_red), .out_green(out_green),
        .out_blue(out_blue), .out_active(out_active), .out_underrun(out_underrun)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    chk_on = 0;
    bit    done = 0;

    int         m_bytes = 1;
    int         m_dflt [3];
    int         m_len  [3];
    int         m_off  [3];
    logic [7:0] e_col  [3];
    logic       e_act, e_und;

    function automatic logic [7:0] ref_comp(logic [31:0] w, int nbytes, int d, int len,
                                            int off, logic act, logic und);
        logic [15:0] fld;
        logic [7:0]  r;
        fld = '0;
        r   = '0;
        if (!act || und || len == 0) return d[7:0];
        for (int j = 0; j < len; j++) begin
            int pos;
            pos = off + j;
            fld[j] = (pos < 32 && pos < 8 * nbytes) ? w[pos] : 1'b0;
        end
        for (int i = 0; i < 8; i++) begin
            if (len >= 8) r[i] = fld[len - 8 + i];
            else          r[i] = fld[len - 1 - ((7 - i) % len)];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bytes = 1;
            for (int c = 0; c < 3; c++) begin
                m_dflt[c] = 0; m_len[c] = 0; m_off[c] = 0; e_col[c] = 8'h00;
            end
            e_act = 1'b0;
            e_und = 1'b0;
        end else begin
            for (int c = 0; c < 3; c++)
                e_col[c] = ref_comp(pix_word, m_bytes, m_dflt[c], m_len[c], m_off[c],
                                    pix_active, pix_underrun);
            e_act = pix_active;
            e_und = pix_underrun;
            if (cfg_we) begin
                if (cfg_sel == 2'd0) m_bytes = int'(cfg_data[4:3]) + 1;
                else begin
                    m_dflt[cfg_sel - 1] = int'(cfg_data[23:16]);
                    m_len [cfg_sel - 1] = int'(cfg_data[11:8]);
                    m_off [cfg_sel - 1] = int'(cfg_data[4:0]);
                end
            end
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("red",      out_red,            e_col[0]);
            chk("green",    out_green,          e_col[1]);
            chk("blue",     out_blue,           e_col[2]);
            chk("active",   {7'd0, out_active}, {7'd0, e_act});
            chk("underrun", {7'd0, out_underrun}, {7'd0, e_und});
        end
    end

    task automatic wr(logic [1:0] s, logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic px(logic [31:0] w, logic a, logic u);
        pix_word = w; pix_active = a; pix_underrun = u;
        @(negedge clk);
    endtask

    task automatic sel_word(logic [1:0] s, int d, int len, int off);
        wr(s, {8'h00, d[7:0], 4'h0, len[3:0], 3'b000, off[4:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_on = 1;
        cur_req = "R1";
        px(32'hFFFF_FFFF, 1'b1, 1'b0);
        px(32'h1234_5678, 1'b1, 1'b1);
        rst_n = 1'b1;
        px(32'hA5A5_A5A5, 1'b1, 1'b0);
        px(32'h0, 1'b0, 1'b0);

        cur_req = "R3";
        wr(2'd0, 32'hFFFF_FFE7 & 32'h0000_0018 | 32'hFFFF_FFE7 & 32'hFFFF_FFE7);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hA712_F8F0);
        wr(2'd2, 32'h5B34_F0E8);
        wr(2'd3, 32'hFF56_F8E0);
        cur_req = "R7";
        for (int i = 0; i < 40; i++) px($urandom, 1'b1, 1'b0);
        sel_word(2'd1, 8'h00, 12, 20);
        sel_word(2'd2, 8'h00, 15, 3);
        sel_word(2'd3, 8'h00, 9, 0);
        for (int i = 0; i < 40; i++) px($urandom, 1'b1, 1'b0);

        cur_req = "R5";
        for (int i = 0; i < 20; i++) px($urandom, 1'($urandom), 1'b0);
        cur_req = "R6";
        sel_word(2'd1, 8'hFF, 8, 16);
        sel_word(2'd2, 8'h00, 8, 8);
        sel_word(2'd3, 8'h00, 8, 0);
        for (int i = 0; i < 20; i++) px($urandom, 1'b1, 1'($urandom));
        px(32'h0012_3456, 1'b1, 1'b1);
        cur_req = "R10";
        for (int i = 0; i < 30; i++) px($urandom, 1'($urandom), 1'($urandom));

        cur_req = "R4";
        sel_word(2'd2, 8'h9C, 0, 5);
        for (int i = 0; i < 15; i++) px($urandom, 1'b1, 1'b0);

        cur_req = "R8";
        for (int l = 1; l < 8; l++) begin
            sel_word(2'd1, 8'h11, l, 0);
            sel_word(2'd2, 8'h22, l, l * 3);
            sel_word(2'd3, 8'h33, l, 31 - l);
            for (int i = 0; i < 12; i++) px($urandom, 1'b1, 1'b0);
        end

        cur_req = "R9";
        for (int b = 0; b < 4; b++) begin
            wr(2'd0, {27'd0, b[1:0], 3'b000});
            sel_word(2'd1, 8'h01, 8, 8 * b + 4);
            sel_word(2'd2, 8'h02, 15, 28);
            sel_word(2'd3, 8'h03, 10, 8 * b);
            for (int i = 0; i < 12; i++) px(32'hFFFF_FFFF ^ $urandom, 1'b1, 1'b0);
        end

        cur_req = "R2";
        for (int b = 0; b < 4; b++) begin
            wr(2'd0, {$urandom} & 32'hFFFF_FFE7 | {27'd0, b[1:0], 3'b000});
            for (int i = 0; i < 6; i++) px($urandom, 1'b1, 1'b0);
        end

        cur_req = "R11";
        sel_word(2'd1, 8'h44, 8, 0);
        px(32'h0000_00C3, 1'b1, 1'b0);
        sel_word(2'd1, 8'h44, 4, 0);
        px(32'h0000_00C3, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            cfg_we = 1'b0; cfg_sel = 2'($urandom); cfg_data = $urandom;
            px($urandom, 1'b1, 1'b0);
        end

        cur_req = "R7";
        for (int i = 0; i < 1500; i++) begin
            if ($urandom % 4 == 0) wr(2'($urandom), $urandom);
            else px($urandom, ($urandom % 8) != 0, ($urandom % 10) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule